// File: doc/BRIEF.md
# Switch Matrix Scanner with Leading-Edge Debounce

The block walks a grid of switches one column at a time. It raises a single column line and waits a few settle cycles. It then samples every row input at once and compares each sample with the debounced level held for that key. A difference is reported at once as a press or release event, with no filtering delay. The key is then locked for a number of full scan passes, so that the contact bounce that follows cannot raise further events. Each key has its own lockout counter, so one bouncing switch never hides activity on the others.

Events leave through a single valid/ready output, one per cycle. If a column shows several changes in the same sample, they are sent one after another, lowest row first, and the scan holds that column until all of them have been accepted. While the consumer withholds ready, the whole scan stops. The default lockout is computed from the clock rate in kHz and a lockout time in microseconds, and suits values from 5 ms to 12 ms. A pass count can also be given directly.

Top module: `kbd_scan_top`

## Requirements
- R1: Exactly one bit of `col_drive` is high in every cycle. Column 0 is driven after reset, and the columns are visited in ascending order, wrapping from the last column back to column 0.
- R2: A high level on row r, sampled while column c is driven, belongs to key index r*COLS + c. The event carries that index on `evt_key`.
- R3: A key whose sampled level differs from its debounced level, and which is not locked, is reported in the same scan pass as that first differing sample. The event has `evt_pressed` = 1 for a closed switch and 0 for an open one.
- R4: After a key reports a change in pass p, its row level is ignored in passes p+1 through p+LOCK_PASSES and examined again in pass p+LOCK_PASSES+1. If the level then differs from the debounced level, that pass reports a new event.
- R5: A press followed by a burst of eight edges, all within the lockout window, yields exactly one event.
- R6: A key in its lockout does not delay or suppress an event from any other key.
- R7: Several changes found in one column sample are emitted on consecutive cycles while ready is high, in ascending row order.
- R8: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_key`, `evt_pressed` and `col_drive` hold their values, and no further event is lost.
- R9: Reset leaves every key released with its lockout cleared and `evt_valid` low. A key held closed through reset is reported as a press during the first scan pass.
- R10: Release edges are reported immediately and followed by a lockout, exactly as press edges are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_drive | output | COLS | One-hot column drive, high on the active column |
| row_sense | input | ROWS | Row levels, high where a closed switch meets the driven column |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Consumer accepts the event; while low with an event pending, the scan stalls |
| evt_key | output | $clog2(ROWS*COLS) | Key index, row*COLS + column |
| evt_pressed | output | 1 | 1 for a press, 0 for a release |

## Verification
The bench sweeps a 4x4 matrix and counts scan passes on the column-0 drive. At the lockout boundary it releases a key one pass before expiry. A timer that is one pass short reports that release a pass early, and one that is a pass long reports it late. Bursts of eight and nine bounce edges check the filter. A level-integrating filter, or a filter with one shared timer, either emits extra events or misses the late settle to the opposite level. A bouncing key runs while another key is pressed, which exposes a lockout that is not kept per key. A four-row burst in one column and a long ready stall catch a wrong priority order, a dropped event, and a column that advances while its event is still pending.

// File: rtl/kbd_scan_pkg.sv
// Shared types and helpers for the switch matrix scanner.
// Assumes nothing beyond the standard language; no state.
package kbd_scan_pkg;

    // Phase of the per-column scan step.
    typedef enum logic [1:0] {
        PH_SETTLE  = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_EMIT    = 2'd2
    } scan_phase_e;

    // Number of whole scan passes that cover a lockout of lock_us microseconds.
    // The pass length uses the shortest pass (settle + capture + one emit
    // cycle per column), so the real lockout is never shorter than asked.
    function automatic int unsigned lockout_passes(
        input int unsigned clk_khz,
        input int unsigned lock_us,
        input int unsigned cols,
        input int unsigned settle
    );
        longint unsigned total_cyc;
        longint unsigned pass_cyc;
        longint unsigned passes;
        total_cyc = 64'(clk_khz) * 64'(lock_us) / 64'd1000;
        pass_cyc  = 64'(cols) * (64'(settle) + 64'd2);
        passes    = (total_cyc + pass_cyc - 64'd1) / pass_cyc;
        return 32'(passes);
    endfunction

endpackage

// File: rtl/kbd_col_seq.sv
// Column sequencer: drives one column at a time, waits SETTLE cycles, then
// gives one capture cycle and an emit phase that lasts until the emitter
// reports the column done. Wraps after the last column and pulses pass_end.
// Assumes adv_en low freezes the whole sequence (stall from the event port).
import kbd_scan_pkg::*;

module kbd_col_seq #(
    parameter int COLS   = 8,
    parameter int SETTLE = 4,
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv_en,
    input  logic           col_done,
    output logic [CW-1:0]  col_idx,
    output logic [COLS-1:0] col_drive,
    output scan_phase_e    phase,
    output logic           pass_end
);
    localparam int SETTLE_EFF = (SETTLE < 1) ? 1 : SETTLE;
    localparam int SW         = $clog2(SETTLE_EFF + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_EFF - 1);
    localparam logic [CW-1:0] COL_LAST    = CW'(COLS - 1);

    logic [SW-1:0] settle_cnt;
    logic          leave_col;

    assign leave_col = adv_en && (phase == PH_EMIT) && col_done;
    assign pass_end  = leave_col && (col_idx == COL_LAST);

    // Phase stepping, settle counting and column advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_SETTLE;
            settle_cnt <= '0;
            col_idx    <= '0;
        end else if (adv_en) begin
            unique case (phase)
                PH_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) begin
                        settle_cnt <= '0;
                        phase      <= PH_CAPTURE;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                PH_CAPTURE: phase <= PH_EMIT;
                PH_EMIT: begin
                    if (col_done) begin
                        phase   <= PH_SETTLE;
                        col_idx <= (col_idx == COL_LAST) ? '0 : col_idx + 1'b1;
                    end
                end
                default: phase <= PH_SETTLE;
            endcase
        end
    end

    // One-hot column decode from the registered index.
    for (genvar c = 0; c < COLS; c++) begin : g_drive
        assign col_drive[c] = (col_idx == CW'(c));
    end

    assert_one_column_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drive) == 1);

    if (COLS > 1) begin : g_rot_chk
        assert_column_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (col_drive != $past(col_drive)) |->
            (col_drive == {$past(col_drive[COLS-2:0]), $past(col_drive[COLS-1])}));
    end

endmodule

// File: rtl/kbd_key_cell.sv
// One key: debounced level plus lockout counter. A take flips the level and
// loads the counter; each pass tick counts it down until zero.
// Assumes take is only raised for an unlocked key and never with tick.
module kbd_key_cell #(
    parameter int LOCK_LOAD = 11,
    localparam int LW       = $clog2(LOCK_LOAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic tick,
    output logic key_state,
    output logic key_locked
);
    logic [LW-1:0] lock_cnt;

    // Level toggle on report, lockout load and per-pass countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_state <= 1'b0;
            lock_cnt  <= '0;
        end else if (take) begin
            key_state <= ~key_state;
            lock_cnt  <= LW'(LOCK_LOAD);
        end else if (tick && (lock_cnt != '0)) begin
            lock_cnt <= lock_cnt - 1'b1;
        end
    end

    assign key_locked = (lock_cnt != '0);

    assert_take_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !key_locked);

endmodule

// File: rtl/kbd_low_pick.sv
// Lowest-index request picker: reports whether any request is set, the
// index of the lowest one and a one-hot grant. Purely combinational.
module kbd_low_pick #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] sel,
    output logic [N-1:0]  grant
);
    // Scan from the top so the lowest set request wins.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) sel = IW'(i);
        end
    end

    assign found = |req;
    assign grant = req & (~req + 1'b1);

endmodule

// File: rtl/kbd_scan_top.sv
// Switch matrix scanner with leading-edge debounce and per-key lockout.
// Each column is sampled after settling; changed, unlocked keys are queued
// for that column and sent one per cycle, lowest row first, then locked for
// LOCK_PASSES further passes. The scan stalls while an event waits on ready.
// Assumes row_sense is already clean and synchronous to clk.
import kbd_scan_pkg::*;

module kbd_scan_top #(
    parameter int ROWS        = 8,
    parameter int COLS        = 8,
    parameter int SETTLE      = 4,
    parameter int CLK_KHZ     = 200000,
    parameter int LOCK_US     = 8000,
    parameter int LOCK_PASSES = int'(kbd_scan_pkg::lockout_passes(CLK_KHZ, LOCK_US, COLS, SETTLE)),
    localparam int KEYS       = ROWS * COLS,
    localparam int KW         = (KEYS > 1) ? $clog2(KEYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [COLS-1:0] col_drive,
    input  logic [ROWS-1:0] row_sense,
    output logic            evt_valid,
    input  logic            evt_ready,
    output logic [KW-1:0]   evt_key,
    output logic            evt_pressed
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [CW-1:0]   col_idx;
    scan_phase_e     phase;
    logic            pass_end;
    logic            adv_en;
    logic            col_done;
    logic            emit_fire;

    logic [KEYS-1:0] key_state;
    logic [KEYS-1:0] key_locked;
    logic [COLS-1:0] row_state  [ROWS];
    logic [COLS-1:0] row_locked [ROWS];
    logic [ROWS-1:0] col_state;
    logic [ROWS-1:0] col_locked;

    logic [ROWS-1:0] pend;
    logic            pick_found;
    logic [RW-1:0]   pick_sel;
    logic [ROWS-1:0] grant;

    assign adv_en    = !(evt_valid && !evt_ready);
    assign emit_fire = adv_en && (phase == PH_EMIT) && pick_found;
    assign col_done  = !pick_found;

    kbd_col_seq #(.COLS(COLS), .SETTLE(SETTLE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_en    (adv_en),
        .col_done  (col_done),
        .col_idx   (col_idx),
        .col_drive (col_drive),
        .phase     (phase),
        .pass_end  (pass_end)
    );

    // Key array, one cell per intersection, plus the view of the active column.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_state[r]  = key_state[r*COLS +: COLS];
        assign row_locked[r] = key_locked[r*COLS +: COLS];
        assign col_state[r]  = row_state[r][col_idx];
        assign col_locked[r] = row_locked[r][col_idx];
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic take_k;
            assign take_k = emit_fire && grant[r] && (col_idx == CW'(c));
            kbd_key_cell #(.LOCK_LOAD(LOCK_PASSES + 1)) u_key (
                .clk        (clk),
                .rst_n      (rst_n),
                .take       (take_k),
                .tick       (pass_end),
                .key_state  (key_state[r*COLS + c]),
                .key_locked (key_locked[r*COLS + c])
            );
        end
    end

    kbd_low_pick #(.N(ROWS)) u_pick (
        .req   (pend),
        .found (pick_found),
        .sel   (pick_sel),
        .grant (grant)
    );

    // Column capture into the pending set and event register handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend        <= '0;
            evt_valid   <= 1'b0;
            evt_key     <= '0;
            evt_pressed <= 1'b0;
        end else begin
            if (adv_en && (phase == PH_CAPTURE)) begin
                pend <= (row_sense ^ col_state) & ~col_locked;
            end else if (emit_fire) begin
                pend <= pend & ~grant;
            end
            if (emit_fire) begin
                evt_valid   <= 1'b1;
                evt_key     <= KW'(32'(pick_sel) * 32'(COLS) + 32'(col_idx));
                evt_pressed <= ~col_state[pick_sel];
            end else if (evt_ready) begin
                evt_valid <= 1'b0;
            end
        end
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=>
        (evt_valid && $stable(evt_key) && $stable(evt_pressed) && $stable(col_drive)));

    assert_pend_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_EMIT) && ($past(phase) == PH_EMIT)) |->
        ((pend & ~$past(pend)) == '0));

endmodule

// File: tb/kbd_scan_top_bench.sv
`timescale 1ns/1ps
module kbd_scan_top_bench;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int SETTLE = 2;
    localparam int LOCKP = 10;
    localparam int KEYS  = ROWS * COLS;
    localparam int KW    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [COLS-1:0] col_drive;
    logic [ROWS-1:0] row_sense;
    logic            evt_valid;
    logic            evt_ready;
    logic [KW-1:0]   evt_key;
    logic            evt_pressed;
    logic [KEYS-1:0] key_down;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kbd_scan_top #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .LOCK_PASSES(LOCKP)) u_kbd_scan_top (
        .clk(clk), .rst_n(rst_n), .col_drive(col_drive), .row_sense(row_sense),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_key(evt_key), .evt_pressed(evt_pressed)
    );

    // Switch matrix model: a row is high where a closed key meets the driven column.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_sense[r] = |(key_down[r*COLS +: COLS] & col_drive);
        end
    end

    // Pass counter and event log.
    int   pass_no = 0;
    int   cyc = 0;
    int   ev_n = 0;
    logic prev_c0 = 1'b0;
    int   ev_idx [256];
    int   ev_prs [256];
    int   ev_pass[256];
    int   ev_cyc [256];

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        prev_c0 <= (col_drive[0] === 1'b1);
        if (col_drive[0] === 1'b1 && prev_c0 == 1'b0) pass_no <= pass_no + 1;
        if (rst_n && evt_valid === 1'b1 && evt_ready === 1'b1 && ev_n < 256) begin
            ev_idx[ev_n]  <= int'(evt_key);
            ev_prs[ev_n]  <= int'(evt_pressed);
            ev_pass[ev_n] <= pass_no;
            ev_cyc[ev_n]  <= cyc;
            ev_n          <= ev_n + 1;
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_event(input int i, input string tag, input int idx, input int prs, input int pas);
        if (i >= ev_n) begin
            chk_eq({tag, " missing event"}, ev_n, i + 1);
        end else begin
            chk_eq({tag, " key"}, ev_idx[i], idx);
            chk_eq({tag, " pressed"}, ev_prs[i], prs);
            if (pas >= 0) chk_eq({tag, " pass"}, ev_pass[i], pas);
        end
    endtask

    task automatic wait_passes(input int n);
        int t;
        t = pass_no + n;
        while (pass_no < t) @(negedge clk);
    endtask

    initial begin
        int base;
        int p;
        evt_ready = 1'b1;
        key_down  = '0;
        key_down[9] = 1'b1;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 column 0 after reset", int'(col_drive), 1);
        chk_eq("R9 no event after reset", int'(evt_valid), 0);

        // R9: key held through reset is pressed in the first pass.
        wait_passes(1);
        chk_eq("R9 one event", ev_n, 1);
        check_event(0, "R9 held at reset", 9, 1, 1);
        wait_passes(LOCKP + 1);
        key_down[9] = 1'b0;
        p = pass_no;
        wait_passes(2);
        check_event(1, "R10 release after reset key", 9, 0, p);

        // R2, R3, R10: every key pressed then released.
        for (int k = 0; k < KEYS; k++) begin
            base = ev_n;
            key_down[k] = 1'b1;
            p = pass_no;
            wait_passes(2);
            chk_eq("R3 one press event", ev_n - base, 1);
            check_event(base, "R2 sweep press", k, 1, p);
            wait_passes(LOCKP);
            key_down[k] = 1'b0;
            p = pass_no;
            wait_passes(2);
            chk_eq("R10 sweep event count", ev_n - base, 2);
            check_event(base + 1, "R10 sweep release", k, 0, p);
        end

        // R4: release one pass before expiry is reported at expiry.
        base = ev_n;
        key_down[0] = 1'b1;
        p = pass_no;
        wait_passes(LOCKP);
        key_down[0] = 1'b0;
        wait_passes(3);
        chk_eq("R4 event count", ev_n - base, 2);
        check_event(base, "R4 press", 0, 1, p);
        check_event(base + 1, "R4 release at expiry", 0, 0, p + LOCKP + 1);

        // R5: eight bounce edges after a press give one event.
        base = ev_n;
        key_down[12] = 1'b1;
        p = pass_no;
        for (int i = 0; i < 8; i++) begin
            wait_passes(1);
            key_down[12] = ~key_down[12];
        end
        wait_passes(LOCKP + 2);
        chk_eq("R5 burst of 8 single event", ev_n - base, 1);
        check_event(base, "R5 burst press", 12, 1, p);

        // R4/R5: release with nine edges settles closed; late press at expiry.
        base = ev_n;
        key_down[12] = 1'b0;
        p = pass_no;
        for (int i = 0; i < 9; i++) begin
            wait_passes(1);
            key_down[12] = ~key_down[12];
        end
        wait_passes(LOCKP + 2);
        chk_eq("R5 burst of 9 event count", ev_n - base, 2);
        check_event(base, "R5 burst release", 12, 0, p);
        check_event(base + 1, "R4 settle after lockout", 12, 1, p + LOCKP + 1);

        // R6: key 0 bounces while key 6 is pressed.
        base = ev_n;
        key_down[0] = 1'b1;
        p = pass_no;
        wait_passes(1);
        key_down[0] = 1'b0;
        wait_passes(1);
        key_down[0] = 1'b1;
        key_down[6] = 1'b1;
        wait_passes(1);
        key_down[0] = 1'b0;
        wait_passes(LOCKP + 1);
        chk_eq("R6 event count", ev_n - base, 3);
        check_event(base, "R6 bouncing key press", 0, 1, p);
        check_event(base + 1, "R6 other key unblocked", 6, 1, p + 2);
        check_event(base + 2, "R6 bouncing key settles", 0, 0, p + LOCKP + 1);

        // R7: four rows of column 1 at once.
        base = ev_n;
        key_down[1] = 1'b1;
        key_down[5] = 1'b1;
        key_down[9] = 1'b1;
        key_down[13] = 1'b1;
        p = pass_no;
        wait_passes(2);
        chk_eq("R7 burst event count", ev_n - base, 4);
        for (int j = 0; j < 4; j++) begin
            check_event(base + j, "R7 ascending rows", 1 + 4 * j, 1, p);
            if (j > 0 && base + j < ev_n)
                chk_eq("R7 consecutive cycles", ev_cyc[base + j] - ev_cyc[base + j - 1], 1);
        end

        // R8: ready held low keeps the event and the column.
        wait_passes(1);
        evt_ready = 1'b0;
        base = ev_n;
        key_down[3] = 1'b1;
        begin
            int n;
            logic [COLS-1:0] snap_col;
            int snap_key;
            n = 0;
            while (evt_valid !== 1'b1 && n < 200) begin
                @(negedge clk);
                n++;
            end
            snap_col = col_drive;
            snap_key = int'(evt_key);
            repeat (20) @(negedge clk);
            chk_eq("R8 valid held", int'(evt_valid), 1);
            chk_eq("R8 key held", int'(evt_key), snap_key);
            chk_eq("R8 key value", int'(evt_key), 3);
            chk_eq("R8 column held", int'(col_drive), int'(snap_col));
            chk_eq("R8 nothing accepted", ev_n - base, 0);
        end
        evt_ready = 1'b1;
        wait_passes(2);
        chk_eq("R8 one event after stall", ev_n - base, 1);
        check_event(base, "R8 delivered", 3, 1, -1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule